// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register Block

This block holds the pin-control registers for a parameterised number of GPIO banks. Each bank has up to 32 pins. The registers sit behind a simple memory-mapped bus that has a single-cycle valid/write strobe. Each bank owns one output-data register, one direction register and one output-enable register. A pin is actively driven only while its direction bit and its enable bit are both 1.

Software changes the output data through two write-only half-word ports per bank. In a port word, the upper sixteen bits are a per-bit keep mask and the lower sixteen bits are the new values. This lets any subset of pins change in a single write, with no read-modify-write. The pin levels come back through a two-flop synchronizer and can be read from a per-bank read-only state register.

Banks may implement fewer than 32 pins. A per-bank mask parameter marks which pins exist. The bits of absent pins read as 0 and cannot be set.

Top module: `gpio_bank_block`

## Requirements
- R1: A write to byte address 0x000 + 8·bank (the low port) updates output bits 15:0 of that bank from write-data bits 15:0.
- R2: A write to byte address 0x004 + 8·bank (the high port) updates output bits 31:16 of that bank from write-data bits 15:0.
- R3: In a port write, write-data bit 16+i is the keep flag for bit i of that half. A data bit is applied only where its keep flag is 0. A write with all sixteen keep flags set leaves the output register unchanged.
- R4: A read of either port address returns 0.
- R5: The direction register at 0x204 + 0x40·bank is readable and writable. Bit value 1 means output.
- R6: The output-enable register at 0x208 + 0x40·bank is readable and writable. Bit value 1 means enabled.
- R7: `pin_oe` bit n is 1 exactly when direction bit n and enable bit n are both 1. `pin_out` shows the output-data register. Both change in the cycle after the write.
- R8: The state register at 0x060 + 4·bank returns `pin_in` as seen through two flops. A level applied before clock edge k is returned by a read issued at edge k+2.
- R9: Bits of unimplemented pins (mask bit 0) read as 0 in every register. Writes never set them, so they never drive `pin_oe`.
- R10: A synchronous active-high reset clears direction, enable, output data, the synchronizer and `bus_rdata`, so every pin starts as an undriven input.
- R11: A read of any unmapped or non-word-aligned address, or of a bank index at or above the bank count, returns 0.
- R12: Read data is registered. It appears after the edge that accepts the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS·32 | Pad input levels, bank b at bits 32b+31:32b |
| pin_out | output | NUM_BANKS·32 | Output data per pin |
| pin_oe | output | NUM_BANKS·32 | Drive enable per pin |

## Verification
Two functions can fall in the same cycle: the capture of a changing pad level by the synchronizer, and a state-register read issued in that very cycle. The bench changes `pin_in` on the same cycle as back-to-back state reads. A behavioural model with a two-stage history then decides which level each read must return. Masked writes to the output register are also interleaved with direction and enable writes, so `pin_oe` and `pin_out` shift in the same cycles. Both outputs are compared every clock against the model.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int ADDR_W = 12;
    localparam int BANK_W = 4;

    localparam logic [ADDR_W-1:0] STATE_BASE = 12'h060;
    localparam logic [ADDR_W-1:0] CFG_BASE   = 12'h200;
    localparam logic [5:0]        DIR_OFS    = 6'h04;
    localparam logic [5:0]        OE_OFS     = 6'h08;

    typedef enum logic [2:0] {
        REG_NONE, REG_LOW, REG_HIGH, REG_STATE, REG_DIR, REG_OE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [BANK_W-1:0]  bank;
    } reg_sel_t;

    function automatic logic [WORD_W-1:0] merge_half(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] wr,
        input logic              upper
    );
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int i = 0; i < HALF_W; i++) begin
            if (!wr[HALF_W+i]) begin
                if (upper) r[HALF_W+i] = wr[i];
                else       r[i]        = wr[i];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] NB_A      = ADDR_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] STATE_LEN = ADDR_W'(4 * NUM_BANKS);

    logic [ADDR_W-1:0] st_off;
    logic [ADDR_W-1:0] cfg_off;

    always_comb begin
        st_off   = addr - STATE_BASE;
        cfg_off  = addr - CFG_BASE;
        sel.kind = REG_NONE;
        sel.bank = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr < STATE_BASE) begin
                if ({3'b000, addr[ADDR_W-1:3]} < NB_A) begin
                    sel.kind = addr[2] ? REG_HIGH : REG_LOW;
                    sel.bank = addr[6:3];
                end
            end else if (st_off < STATE_LEN) begin
                sel.kind = REG_STATE;
                sel.bank = st_off[5:2];
            end else if (addr >= CFG_BASE) begin
                if ({6'b000000, cfg_off[ADDR_W-1:6]} < NB_A) begin
                    sel.bank = cfg_off[9:6];
                    if (cfg_off[5:0] == DIR_OFS)     sel.kind = REG_DIR;
                    else if (cfg_off[5:0] == OE_OFS) sel.kind = REG_OE;
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter logic [WORD_W-1:0] IMPL = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_low,
    input  logic              wr_high,
    input  logic              wr_dir,
    input  logic              wr_oe,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] dir_q,
    output logic [WORD_W-1:0] oe_q,
    output logic [WORD_W-1:0] out_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            oe_q  <= '0;
            out_q <= '0;
        end else begin
            if (wr_dir)  dir_q <= wdata & IMPL;
            if (wr_oe)   oe_q  <= wdata & IMPL;
            if (wr_low)  out_q <= merge_half(out_q, wdata, 1'b0) & IMPL;
            if (wr_high) out_q <= merge_half(out_q, wdata, 1'b1) & IMPL;
        end
    end

    // R3: an all-keep port write leaves the output register untouched
    assert_keep_all_R3: assert property (@(posedge clk) disable iff (rst)
        ((wr_low || wr_high) && (&wdata[31:16])) |=> $stable(out_q));

    // R5: direction register changes only on its own write
    assert_dir_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(dir_q));

    // R6: enable register changes only on its own write
    assert_oe_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_oe |=> $stable(oe_q));
endmodule

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank_block.sv
`timescale 1ns/1ps
module gpio_bank_block
    import gpio_bank_pkg::*;
#(
    parameter int                       NUM_BANKS  = 3,
    parameter logic [NUM_BANKS*32-1:0]  IMPL_MASKS = {32'hFFFF_FFFF, 32'h03FF_FFFF, 32'h003F_FFFF}
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [11:0]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_BANKS*32-1:0]     pin_in,
    output logic [NUM_BANKS*32-1:0]     pin_out,
    output logic [NUM_BANKS*32-1:0]     pin_oe
);
    localparam int PINS = NUM_BANKS * WORD_W;

    reg_sel_t          sel;
    logic [PINS-1:0]   sync_q;
    logic [WORD_W-1:0] dir_w [NUM_BANKS];
    logic [WORD_W-1:0] oe_w  [NUM_BANKS];
    logic [WORD_W-1:0] out_w [NUM_BANKS];
    logic [WORD_W-1:0] rd_next;
    logic              wr_en;
    logic              rd_en;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_pin_sync #(.W(PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_q)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && (sel.bank == BANK_W'(b));

        gpio_bank_regs #(.IMPL(IMPL_MASKS[b*WORD_W +: WORD_W])) u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_low  (hit && sel.kind == REG_LOW),
            .wr_high (hit && sel.kind == REG_HIGH),
            .wr_dir  (hit && sel.kind == REG_DIR),
            .wr_oe   (hit && sel.kind == REG_OE),
            .wdata   (bus_wdata),
            .dir_q   (dir_w[b]),
            .oe_q    (oe_w[b]),
            .out_q   (out_w[b])
        );

        assign pin_out[b*WORD_W +: WORD_W] = out_w[b];
        assign pin_oe[b*WORD_W +: WORD_W]  = dir_w[b] & oe_w[b];
    end

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel.bank == BANK_W'(b)) begin
                case (sel.kind)
                    REG_STATE: rd_next = sync_q[b*WORD_W +: WORD_W] & IMPL_MASKS[b*WORD_W +: WORD_W];
                    REG_DIR:   rd_next = dir_w[b];
                    REG_OE:    rd_next = oe_w[b];
                    default:   rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_next;
    end

    // R4: port reads return zero
    assert_port_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (sel.kind == REG_LOW || sel.kind == REG_HIGH)) |=> (bus_rdata == '0));

    // R11: unmapped reads return zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel.kind == REG_NONE) |=> (bus_rdata == '0));

    // R12: read data holds between reads
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(bus_rdata));

    // R9: absent pins are never driven
    assert_absent_undriven_R9: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~IMPL_MASKS) == '0));
endmodule

// File: tb/gpio_bank_block_tb.sv
`timescale 1ns/1ps
module gpio_bank_block_tb;
    localparam int NB = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [11:0]       bus_addr  = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NB*32-1:0]  pin_in = '0;
    logic [NB*32-1:0]  pin_out;
    logic [NB*32-1:0]  pin_oe;

    always #5 clk = ~clk;

    gpio_bank_block u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int vectors = 0;
    int fails   = 0;
    bit started = 0;
    bit done    = 0;
    string cur_req = "R10";
    string rd_req  = "R10";
    string wr_req  = "R10";

    // reference model state
    logic [31:0]      m_dir [NB];
    logic [31:0]      m_oe  [NB];
    logic [31:0]      m_out [NB];
    logic [NB*32-1:0] m_s1, m_s2;
    logic [31:0]      m_rdata;

    function automatic logic [31:0] impl(input int b);
        case (b)
            0: return 32'h003F_FFFF;
            1: return 32'h03FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // kind: 0 none, 1 low port, 2 high port, 3 state, 4 dir, 5 enable
    function automatic void decode(input int a, output int kind, output int bank);
        kind = 0; bank = 0;
        if (a % 4 != 0) return;
        if (a < 'h60) begin
            bank = a / 8;
            if (bank < NB) kind = (a % 8 == 4) ? 2 : 1;
        end else if (a < 'h60 + 4 * NB) begin
            kind = 3; bank = (a - 'h60) / 4;
        end else if (a >= 'h200) begin
            bank = (a - 'h200) / 64;
            if (bank < NB) begin
                if ((a - 'h200) % 64 == 4) kind = 4;
                else if ((a - 'h200) % 64 == 8) kind = 5;
            end
        end
    endfunction

    always @(posedge clk) begin
        int kind, bank;
        logic [31:0] v;
        started <= 1'b1;
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                m_dir[b] = '0; m_oe[b] = '0; m_out[b] = '0;
            end
            m_s1 = '0; m_s2 = '0; m_rdata = '0;
        end else begin
            decode(int'(bus_addr), kind, bank);
            if (bus_valid && !bus_write) begin
                rd_req = cur_req;
                case (kind)
                    3: m_rdata = m_s2[bank*32 +: 32] & impl(bank);
                    4: m_rdata = m_dir[bank];
                    5: m_rdata = m_oe[bank];
                    default: m_rdata = '0;
                endcase
            end
            if (bus_valid && bus_write) begin
                wr_req = cur_req;
                case (kind)
                    1, 2: begin
                        v = m_out[bank];
                        for (int i = 0; i < 16; i++)
                            if (bus_wdata[16+i] == 1'b0) v[(kind == 2 ? 16 : 0) + i] = bus_wdata[i];
                        m_out[bank] = v & impl(bank);
                    end
                    4: m_dir[bank] = bus_wdata & impl(bank);
                    5: m_oe[bank]  = bus_wdata & impl(bank);
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [NB*32-1:0] e_out, e_oe;
            for (int b = 0; b < NB; b++) begin
                e_out[b*32 +: 32] = m_out[b];
                e_oe[b*32 +: 32]  = m_dir[b] & m_oe[b];
            end
            vectors++;
            if (bus_rdata !== m_rdata) begin
                fails++;
                $display("FAIL %s bus_rdata actual=%h expected=%h", rd_req, bus_rdata, m_rdata);
            end
            if (pin_out !== e_out) begin
                fails++;
                $display("FAIL R7 (after %s) pin_out actual=%h expected=%h", wr_req, pin_out, e_out);
            end
            if (pin_oe !== e_oe) begin
                fails++;
                $display("FAIL R7 (after %s) pin_oe actual=%h expected=%h", wr_req, pin_oe, e_oe);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d, input string req);
        @(negedge clk);
        cur_req = req; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    endtask

    task automatic rd(input int a, input string req);
        @(negedge clk);
        cur_req = req; bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'(a); bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_valid = 1'b0; bus_write = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int addrs[12] = '{'h000, 'h004, 'h008, 'h014, 'h060, 'h064, 'h068,
                          'h204, 'h208, 'h248, 'h288, 'h284};
        rst = 1'b1;
        idle(3);
        @(negedge clk); rst = 1'b0;
        // R10: reset state, everything reads zero
        for (int b = 0; b < NB; b++) begin
            rd('h204 + 64*b, "R10"); rd('h208 + 64*b, "R10"); rd('h60 + 4*b, "R10");
        end
        // R5 and R9: direction write on a 22-pin bank
        wr('h204, 32'hFFFF_FFFF, "R9"); rd('h204, "R5");
        // R6: enable register
        wr('h208, 32'h0000_FFFF, "R6"); rd('h208, "R6");
        // R1: low port; R2: high port (bank 0 keeps only bits 21:16)
        wr('h000, 32'h0000_A5A5, "R1");
        wr('h004, 32'h0000_FFFF, "R2");
        // R3: partial keep, then all-keep writes
        wr('h000, 32'hFF00_0000, "R3");
        wr('h004, 32'hFFFF_0000, "R3");
        wr('h000, 32'hFFFF_FFFF, "R3");
        // R4: port reads return zero
        rd('h000, "R4"); rd('h004, "R4"); rd('h014, "R4");
        // R7: bank 2 full width, dir and enable overlap
        wr('h284, 32'hF0F0_F0F0, "R7");
        wr('h288, 32'hFF00_FF00, "R7");
        wr('h010, 32'h0000_1234, "R1");
        wr('h014, 32'h0000_CAFE, "R2");
        wr('h244, 32'hFFFF_FFFF, "R9");
        wr('h248, 32'hFFFF_FFFF, "R9");
        wr('h00C, 32'h0000_FFFF, "R9");
        rd('h244, "R9");
        // R8: pin change in the same cycle as back-to-back state reads
        @(negedge clk); pin_in = {32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFF};
        cur_req = "R8"; bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h060;
        rd('h060, "R8"); rd('h060, "R8"); rd('h064, "R8"); rd('h068, "R8");
        @(negedge clk); pin_in = ~pin_in; bus_addr = 12'h068;
        rd('h068, "R8"); rd('h068, "R8"); rd('h060, "R8");
        // R11: unmapped, misaligned, out-of-range bank
        rd('h018, "R11"); rd('h06C, "R11"); rd('h2C4, "R11");
        rd('h206, "R11"); rd('h20C, "R11"); rd('h100, "R11");
        wr('h018, 32'h0000_FFFF, "R11"); wr('h2C4, 32'hFFFF_FFFF, "R11");
        // R12: read data held across idle cycles
        rd('h284, "R12"); idle(4);
        // mixed random traffic across all registers
        for (int n = 0; n < 400; n++) begin
            int a = addrs[$urandom_range(0, 11)];
            if ($urandom_range(0, 3) == 0) pin_in = {$urandom, $urandom, $urandom};
            if ($urandom_range(0, 1) == 1) wr(a, $urandom, "R3");
            else if ($urandom_range(0, 3) == 0) idle(1);
            else rd(a, "R8");
        end
        // R10: reset in the middle of traffic
        @(negedge clk); rst = 1'b1; bus_valid = 1'b0;
        idle(2);
        @(negedge clk); rst = 1'b0;
        rd('h204, "R10"); rd('h288, "R10"); rd('h060, "R10");
        idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule